// File: doc/BRIEF.md
# Deep-Idle Power Sequencing Controller

This block steers a chip into and back out of its deepest idle state short of full power-off. Software first programs a standby-mode field, sets a deep-idle enable and decides whether the top logic domain stays powered. The processor then signals that it is waiting for an interrupt. From that point the block runs a fixed shutdown order. It drains the system bus and then the memory controller, and asks the DRAM to go into self-refresh. Each of these three steps is a request held until the outside circuit acknowledges it. The block then gates the clocks, switches off PLLs and switches off the selected oscillators. The always-on slow oscillator is never stopped.

A wakeup event brings every oscillator back. If any oscillator had been stopped, the block waits a programmable settling interval, then ungates the clocks and drops its requests. A wakeup that arrives during the shutdown lets the step in progress finish, then skips the remaining steps and turns back. A missing acknowledge is caught by a timeout, which raises an error and turns back in the same way. I/O and PLL-input retention stay asserted after the exit until software clears them with write-one pulses. Re-enabling the PLLs is also left to software, and a counter reports when the lock interval has elapsed.

Top module: `didle_seq`

## Requirements
- R1: Under reset all PLL and oscillator enables are 1, all requests and the clock mask are 0, both retention outputs are 1, lock_done, timeout_err and asleep are 0, and pmu_irq_en is 1.
- R2: A shutdown starts from idle only when standby_mode equals 2'b01, deep_en is 1 and wfi is 1 at the same clock edge; bus_drain_req rises on that edge. No other combination of these three inputs starts it.
- R3: The shutdown runs in this order: bus drain, memory drain, self-refresh, clock mask, PLL off, oscillator off. mem_drain_req rises only after bus_drain_ack, and sref_req rises only after mem_drain_ack. When each acknowledge comes back in the cycle after its request, asleep rises 5 cycles after the arming edge.
- R4: In the PLL step, pll_en keeps only bit KEEP_PLL set when top_keep is 0, and keeps all bits unchanged when top_keep is 1.
- R5: In the oscillator step, osc_en becomes the inverse of osc_off_sel, except that bit 0 (the slow always-on oscillator) stays 1.
- R6: A wake pulse while asleep sets all osc_en bits. If any oscillator was off, clk_mask falls OSC_WAIT+2 cycles after the wake edge; otherwise it falls 2 cycles after. Requests fall together with clk_mask, and pll_en is left as it was in sleep.
- R7: A wake during the shutdown lets the step in progress complete, skips every later step and runs the exit. A wake during the memory drain never raises sref_req; a wake during self-refresh never raises clk_mask and never switches a PLL off.
- R8: If the pending step's acknowledge is missing for ACK_TIMEOUT cycles, timeout_err rises and the exit runs. timeout_err holds until the next arming edge clears it.
- R9: pmu_irq_en is 0 from the arming edge through the oscillator step when int_mask_cfg is 1, and stays 1 when int_mask_cfg is 0.
- R10: io_ret and pll_ret are set whenever sleep is entered. A one-cycle sw_io_rel or sw_pll_rel pulse clears its own bit only while the sequencer is idle and is ignored while asleep.
- R11: An sw_pll_start pulse in idle sets all pll_en bits and clears lock_done; lock_done rises exactly LOCK_WAIT cycles after that edge. Entering sleep clears lock_done.
- R12: asleep is 1 exactly while the sequencer waits in the sleep state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_mode | input | 2 | Standby-on-wait configuration, 2'b01 selects deep idle |
| deep_en | input | 1 | Deep-idle enable bit |
| top_keep | input | 1 | 1 keeps the top domain powered, so no PLL is switched off |
| int_mask_cfg | input | 1 | Block PMU interrupts during the shutdown |
| osc_off_sel | input | NUM_OSC | Oscillators to stop, bit 0 has no effect |
| wfi | input | 1 | Processor wait-for-interrupt indication |
| wake | input | 1 | Wakeup event |
| sw_io_rel | input | 1 | Write-one pulse releasing I/O retention |
| sw_pll_rel | input | 1 | Write-one pulse releasing PLL-input retention |
| sw_pll_start | input | 1 | Software PLL re-enable, starts the lock wait |
| bus_drain_ack | input | 1 | Bus drained |
| mem_drain_ack | input | 1 | Memory controller drained |
| sref_ack | input | 1 | DRAM in self-refresh |
| bus_drain_req | output | 1 | Bus drain request |
| mem_drain_req | output | 1 | Memory-controller drain request |
| sref_req | output | 1 | Self-refresh request |
| clk_mask | output | 1 | Clock gating to the blocks that stop |
| pll_en | output | NUM_PLL | PLL enables |
| osc_en | output | NUM_OSC | Oscillator enables, bit 0 is the slow oscillator |
| io_ret | output | 1 | I/O pad retention |
| pll_ret | output | 1 | PLL-input retention |
| lock_done | output | 1 | Lock interval elapsed |
| timeout_err | output | 1 | Acknowledge timeout seen |
| pmu_irq_en | output | 1 | PMU interrupts allowed |
| asleep | output | 1 | Sequencer is in sleep |

## Verification
The arming logic is swept over all sixteen combinations of standby_mode, deep_en and wfi. This separates the single starting pattern from its neighbours that differ in one bit, and checks the interrupt gate under both mask settings. Full shutdown and wake cycles then run for both top_keep values and every oscillator selection. These separate a kept PLL from a stopped one, and an exit that has to wait for settling from one that does not; the settling time is measured in cycles from the wake edge. Stalled acknowledges isolate the timeout count and the handshake ordering. Wakes placed in the memory drain and in the self-refresh step show which later steps are skipped. Release pulses given while asleep and while idle tell the ignored write from the effective one.

// File: rtl/didle_pkg.sv
package didle_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_BUS,
    S_MEM,
    S_SREF,
    S_PLL,
    S_OSC,
    S_SLEEP,
    S_EXIT,
    S_WAIT,
    S_RESUME
  } dseq_st_e;
endpackage

// File: rtl/didle_tmr.sv
module didle_tmr #(
  parameter int LIMIT = 33
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic hit
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign hit = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (start) begin
      cnt <= '0;
    end else if (run && !hit) begin
      cnt <= cnt + CW'(1);
    end
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt <= LAST));
endmodule

// File: rtl/didle_ret.sv
module didle_ret #(
  parameter int LOCK_WAIT = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic idle_i,
  input  logic sleep_go_i,
  input  logic io_rel_i,
  input  logic pll_rel_i,
  input  logic lock_go_i,
  output logic io_ret_o,
  output logic pll_ret_o,
  output logic lock_done_o
);
  logic lock_busy;
  logic lock_hit;

  didle_tmr #(.LIMIT(LOCK_WAIT)) u_lock_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (lock_go_i),
    .run   (lock_busy),
    .hit   (lock_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      io_ret_o    <= 1'b1;
      pll_ret_o   <= 1'b1;
      lock_busy   <= 1'b0;
      lock_done_o <= 1'b0;
    end else begin
      if (sleep_go_i) begin
        io_ret_o    <= 1'b1;
        pll_ret_o   <= 1'b1;
        lock_busy   <= 1'b0;
        lock_done_o <= 1'b0;
      end else begin
        if (idle_i && io_rel_i)  io_ret_o  <= 1'b0;
        if (idle_i && pll_rel_i) pll_ret_o <= 1'b0;
        if (lock_go_i) begin
          lock_busy   <= 1'b1;
          lock_done_o <= 1'b0;
        end else if (lock_busy && lock_hit) begin
          lock_busy   <= 1'b0;
          lock_done_o <= 1'b1;
        end
      end
    end
  end

  // R10
  io_rel_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(io_ret_o) |-> $past(idle_i && io_rel_i));

  // R10
  pll_rel_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_ret_o) |-> $past(idle_i && pll_rel_i));

  // R11
  lock_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_done_o) |-> $past(lock_busy));
endmodule

// File: rtl/didle_seq.sv
module didle_seq
  import didle_pkg::*;
#(
  parameter int NUM_PLL     = 4,
  parameter int KEEP_PLL    = 3,
  parameter int NUM_OSC     = 3,
  parameter int OSC_WAIT    = 33,
  parameter int LOCK_WAIT   = 10,
  parameter int ACK_TIMEOUT = 1024
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         standby_mode,
  input  logic               deep_en,
  input  logic               top_keep,
  input  logic               int_mask_cfg,
  input  logic [NUM_OSC-1:0] osc_off_sel,
  input  logic               wfi,
  input  logic               wake,
  input  logic               sw_io_rel,
  input  logic               sw_pll_rel,
  input  logic               sw_pll_start,
  input  logic               bus_drain_ack,
  input  logic               mem_drain_ack,
  input  logic               sref_ack,
  output logic               bus_drain_req,
  output logic               mem_drain_req,
  output logic               sref_req,
  output logic               clk_mask,
  output logic [NUM_PLL-1:0] pll_en,
  output logic [NUM_OSC-1:0] osc_en,
  output logic               io_ret,
  output logic               pll_ret,
  output logic               lock_done,
  output logic               timeout_err,
  output logic               pmu_irq_en,
  output logic               asleep
);
  localparam logic [1:0]         MODE_DEEP = 2'b01;
  localparam logic [NUM_OSC-1:0] SLOW_OSC  = NUM_OSC'(1);

  dseq_st_e st, nxt;

  logic               wake_pend;
  logic               woke;
  logic               arm;
  logic               hs_st;
  logic               cur_ack;
  logic               ack_hit;
  logic               ack_start;
  logic               tmo_fire;
  logic               osc_hit;
  logic               osc_start;
  logic               any_osc_off;
  logic               nxt_entry;
  logic               pll_restore;
  logic               sleep_go;
  logic [NUM_PLL-1:0] pll_keep;
  logic [NUM_OSC-1:0] osc_keep;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PLL; gi++) begin : g_keep
      assign pll_keep[gi] = (gi == KEEP_PLL);
    end
  endgenerate

  assign osc_keep    = ~osc_off_sel | SLOW_OSC;
  assign any_osc_off = ~&osc_en;
  assign woke        = wake | wake_pend;
  assign arm         = (standby_mode == MODE_DEEP) && deep_en && wfi;
  assign hs_st       = (st == S_BUS) || (st == S_MEM) || (st == S_SREF);
  assign tmo_fire    = hs_st && !cur_ack && ack_hit;
  assign ack_start   = (nxt != st) &&
                       ((nxt == S_BUS) || (nxt == S_MEM) || (nxt == S_SREF));
  assign osc_start   = (nxt == S_WAIT) && (st != S_WAIT);
  assign nxt_entry   = (nxt == S_BUS) || (nxt == S_MEM) || (nxt == S_SREF) ||
                       (nxt == S_PLL) || (nxt == S_OSC);
  assign pll_restore = (st == S_IDLE) && sw_pll_start;
  assign sleep_go    = (st == S_OSC);

  always_comb begin
    case (st)
      S_BUS:   cur_ack = bus_drain_ack;
      S_MEM:   cur_ack = mem_drain_ack;
      S_SREF:  cur_ack = sref_ack;
      default: cur_ack = 1'b0;
    endcase
  end

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:   if (arm) nxt = S_BUS;
      S_BUS:    if (cur_ack) nxt = woke ? S_EXIT : S_MEM;
                else if (ack_hit) nxt = S_EXIT;
      S_MEM:    if (cur_ack) nxt = woke ? S_EXIT : S_SREF;
                else if (ack_hit) nxt = S_EXIT;
      S_SREF:   if (cur_ack) nxt = woke ? S_EXIT : S_PLL;
                else if (ack_hit) nxt = S_EXIT;
      S_PLL:    nxt = woke ? S_EXIT : S_OSC;
      S_OSC:    nxt = S_SLEEP;
      S_SLEEP:  if (woke) nxt = S_EXIT;
      S_EXIT:   nxt = any_osc_off ? S_WAIT : S_RESUME;
      S_WAIT:   if (osc_hit) nxt = S_RESUME;
      S_RESUME: nxt = S_IDLE;
      default:  nxt = S_IDLE;
    endcase
  end

  didle_tmr #(.LIMIT(ACK_TIMEOUT)) u_ack_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (ack_start),
    .run   (hs_st),
    .hit   (ack_hit)
  );

  didle_tmr #(.LIMIT(OSC_WAIT)) u_osc_tmr (
    .clk   (clk),
    .rst   (rst),
    .start (osc_start),
    .run   (st == S_WAIT),
    .hit   (osc_hit)
  );

  didle_ret #(.LOCK_WAIT(LOCK_WAIT)) u_ret (
    .clk         (clk),
    .rst         (rst),
    .idle_i      (st == S_IDLE),
    .sleep_go_i  (sleep_go),
    .io_rel_i    (sw_io_rel),
    .pll_rel_i   (sw_pll_rel),
    .lock_go_i   (pll_restore),
    .io_ret_o    (io_ret),
    .pll_ret_o   (pll_ret),
    .lock_done_o (lock_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= S_IDLE;
      bus_drain_req <= 1'b0;
      mem_drain_req <= 1'b0;
      sref_req      <= 1'b0;
      clk_mask      <= 1'b0;
      pll_en        <= '1;
      osc_en        <= '1;
      wake_pend     <= 1'b0;
      timeout_err   <= 1'b0;
      pmu_irq_en    <= 1'b1;
      asleep        <= 1'b0;
    end else begin
      st         <= nxt;
      asleep     <= (nxt == S_SLEEP);
      pmu_irq_en <= !(int_mask_cfg && nxt_entry);
      if (wake && (hs_st || st == S_PLL || st == S_OSC || st == S_SLEEP))
        wake_pend <= 1'b1;
      if (tmo_fire) timeout_err <= 1'b1;
      case (st)
        S_IDLE: begin
          if (nxt == S_BUS) begin
            bus_drain_req <= 1'b1;
            timeout_err   <= 1'b0;
          end
          if (pll_restore) pll_en <= '1;
        end
        S_BUS:  if (nxt == S_MEM)  mem_drain_req <= 1'b1;
        S_MEM:  if (nxt == S_SREF) sref_req <= 1'b1;
        S_SREF: if (nxt == S_PLL)  clk_mask <= 1'b1;
        S_PLL:  if (!top_keep) pll_en <= pll_en & pll_keep;
        S_OSC:  osc_en <= osc_keep;
        S_EXIT: osc_en <= '1;
        S_RESUME: begin
          bus_drain_req <= 1'b0;
          mem_drain_req <= 1'b0;
          sref_req      <= 1'b0;
          clk_mask      <= 1'b0;
          wake_pend     <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  // R3
  sref_order_chk: assert property (@(posedge clk) disable iff (rst)
    sref_req |-> (mem_drain_req && bus_drain_req));

  // R3
  mask_order_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_mask) |-> sref_req);

  // R6
  unmask_osc_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(clk_mask) |-> (&osc_en));

  // R11
  lock_pll_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lock_done) |-> (&pll_en));

  // R5
  slow_osc_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(asleep) |-> osc_en[0]);

  generate
    for (gi = 0; gi < NUM_PLL; gi++) begin : g_pll_chk
      // R4
      pll_off_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_en[gi]) |-> $past(st == S_PLL && !top_keep));
    end
  endgenerate
endmodule

// File: tb/didle_seq_tb_top.sv
module didle_seq_tb_top;
  localparam int NP = 3;
  localparam int KP = 1;
  localparam int NO = 3;
  localparam int OW = 5;
  localparam int LW = 3;
  localparam int AT = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] standby_mode = 2'b00;
  logic deep_en = 1'b0, top_keep = 1'b0, int_mask_cfg = 1'b0;
  logic [NO-1:0] osc_off_sel = '0;
  logic wfi = 1'b0, wake = 1'b0;
  logic sw_io_rel = 1'b0, sw_pll_rel = 1'b0, sw_pll_start = 1'b0;
  logic ack_bus_on = 1'b0, ack_mem_on = 1'b0, ack_sref_on = 1'b0;
  logic bus_drain_ack, mem_drain_ack, sref_ack;
  logic bus_drain_req, mem_drain_req, sref_req, clk_mask;
  logic [NP-1:0] pll_en;
  logic [NO-1:0] osc_en;
  logic io_ret, pll_ret, lock_done, timeout_err, pmu_irq_en, asleep;

  int n_chk = 0;
  int n_bad = 0;
  logic clr = 1'b1;
  logic order_bad, seen_sref, seen_mask, seen_sleep;

  always #2.5 clk = ~clk;

  assign bus_drain_ack = ack_bus_on & bus_drain_req;
  assign mem_drain_ack = ack_mem_on & mem_drain_req;
  assign sref_ack      = ack_sref_on & sref_req;

  didle_seq #(
    .NUM_PLL(NP), .KEEP_PLL(KP), .NUM_OSC(NO),
    .OSC_WAIT(OW), .LOCK_WAIT(LW), .ACK_TIMEOUT(AT)
  ) dut_i (
    .clk(clk), .rst(rst), .standby_mode(standby_mode), .deep_en(deep_en),
    .top_keep(top_keep), .int_mask_cfg(int_mask_cfg), .osc_off_sel(osc_off_sel),
    .wfi(wfi), .wake(wake), .sw_io_rel(sw_io_rel), .sw_pll_rel(sw_pll_rel),
    .sw_pll_start(sw_pll_start), .bus_drain_ack(bus_drain_ack),
    .mem_drain_ack(mem_drain_ack), .sref_ack(sref_ack),
    .bus_drain_req(bus_drain_req), .mem_drain_req(mem_drain_req),
    .sref_req(sref_req), .clk_mask(clk_mask), .pll_en(pll_en), .osc_en(osc_en),
    .io_ret(io_ret), .pll_ret(pll_ret), .lock_done(lock_done),
    .timeout_err(timeout_err), .pmu_irq_en(pmu_irq_en), .asleep(asleep)
  );

  // ordering and event monitor, sampled just after each rising edge
  always @(posedge clk) begin
    #1;
    if (clr) begin
      order_bad  = 1'b0;
      seen_sref  = 1'b0;
      seen_mask  = 1'b0;
      seen_sleep = 1'b0;
    end else if (!rst) begin
      if ((sref_req && !mem_drain_req) || (mem_drain_req && !bus_drain_req) ||
          (clk_mask && !sref_req) || ((osc_en != 3'b111) && !clk_mask))
        order_bad = 1'b1;
      if (sref_req) seen_sref = 1'b1;
      if (clk_mask) seen_mask = 1'b1;
      if (asleep) seen_sleep = 1'b1;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic arm_pulse();
    wfi = 1'b1;
    tick();
    wfi = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100 && (bus_drain_req || clk_mask); i++) tick();
  endtask

  task automatic clear_flags();
    clr = 1'b1;
    tick();
    clr = 1'b0;
  endtask

  task automatic lock_run();
    int n;
    sw_pll_start = 1'b1;
    tick();
    sw_pll_start = 1'b0;
    n = 0;
    while (!lock_done && n < 100) begin
      tick();
      n++;
    end
    chk("R11 lock wait cycles", n, LW);
    chk("R11 all PLLs enabled", int'(pll_en), 7);
  endtask

  task automatic full_cycle(input int tk, input int sel);
    int n, exp_pll, exp_osc, exp_exit;
    top_keep    = tk[0];
    osc_off_sel = sel[NO-1:0];
    clear_flags();
    arm_pulse();
    n = 0;
    while (!asleep && n < 50) begin
      tick();
      n++;
    end
    exp_pll = (tk != 0) ? 7 : (1 << KP);
    exp_osc = (~sel | 1) & 7;
    chk("R3 entry length", n, 5);
    chk("R12 asleep", int'(asleep), 1);
    chk("R3 order", int'(order_bad), 0);
    chk("R3 clock masked", int'(clk_mask), 1);
    chk("R4 pll_en", int'(pll_en), exp_pll);
    chk("R5 osc_en", int'(osc_en), exp_osc);
    chk("R10 io_ret set", int'(io_ret), 1);
    chk("R10 pll_ret set", int'(pll_ret), 1);
    chk("R11 lock_done cleared", int'(lock_done), 0);
    sw_io_rel = 1'b1;
    tick();
    sw_io_rel = 1'b0;
    chk("R10 release ignored asleep", int'(io_ret), 1);
    wake = 1'b1;
    tick();
    wake = 1'b0;
    chk("R12 asleep cleared", int'(asleep), 0);
    n = 0;
    while (clk_mask && n < 100) begin
      tick();
      n++;
    end
    exp_exit = ((sel & 6) != 0) ? OW + 2 : 2;
    chk("R6 exit latency", n, exp_exit);
    chk("R6 osc restored", int'(osc_en), 7);
    chk("R6 pll kept", int'(pll_en), exp_pll);
    chk("R6 requests dropped", int'({bus_drain_req, mem_drain_req, sref_req}), 0);
    sw_io_rel = 1'b1;
    tick();
    sw_io_rel = 1'b0;
    chk("R10 io release", int'(io_ret), 0);
    chk("R10 pll_ret kept", int'(pll_ret), 1);
    sw_pll_rel = 1'b1;
    tick();
    sw_pll_rel = 1'b0;
    chk("R10 pll release", int'(pll_ret), 0);
    lock_run();
  endtask

  initial begin : main
    int n;
    logic exp_arm;
    repeat (4) tick();
    rst = 1'b0;
    clr = 1'b0;
    // R1 reset state
    chk("R1 pll_en", int'(pll_en), 7);
    chk("R1 osc_en", int'(osc_en), 7);
    chk("R1 requests", int'({bus_drain_req, mem_drain_req, sref_req, clk_mask}), 0);
    chk("R1 retention", int'({io_ret, pll_ret}), 3);
    chk("R1 flags", int'({lock_done, timeout_err, asleep}), 0);
    chk("R1 pmu_irq_en", int'(pmu_irq_en), 1);
    tick();
    lock_run();

    // R2 / R9 arming sweep with acknowledges held back
    int_mask_cfg = 1'b1;
    for (int m = 0; m < 4; m++) begin
      for (int d = 0; d < 2; d++) begin
        for (int w = 0; w < 2; w++) begin
          standby_mode = m[1:0];
          deep_en      = d[0];
          wfi          = w[0];
          tick();
          wfi = 1'b0;
          exp_arm = (m == 1) && (d == 1) && (w == 1);
          chk("R2 arming", int'(bus_drain_req), int'(exp_arm));
          chk("R9 irq gate", int'(pmu_irq_en), int'(!exp_arm));
          if (exp_arm) begin
            wake = 1'b1;
            ack_bus_on = 1'b1;
            tick();
            wake = 1'b0;
            wait_idle();
            ack_bus_on = 1'b0;
          end
        end
      end
    end
    int_mask_cfg = 1'b0;
    standby_mode = 2'b01;
    deep_en = 1'b1;
    arm_pulse();
    chk("R9 irq open without mask", int'(pmu_irq_en), 1);
    wake = 1'b1;
    ack_bus_on = 1'b1;
    tick();
    wake = 1'b0;
    wait_idle();

    // full shutdown / wake sweep
    ack_mem_on = 1'b1;
    ack_sref_on = 1'b1;
    for (int tk = 0; tk < 2; tk++)
      for (int sel = 0; sel < 8; sel++)
        full_cycle(tk, sel);

    // R8 timeout on the memory drain
    ack_mem_on = 1'b0;
    osc_off_sel = '0;
    clear_flags();
    arm_pulse();
    for (int i = 0; i < 20 && !mem_drain_req; i++) tick();
    n = 0;
    while (!timeout_err && n < 50) begin
      tick();
      n++;
    end
    chk("R8 timeout cycles", n, AT);
    chk("R3 no sref without mem ack", int'(seen_sref), 0);
    wait_idle();
    chk("R8 error held", int'(timeout_err), 1);
    ack_mem_on = 1'b1;
    arm_pulse();
    chk("R8 error cleared on arming", int'(timeout_err), 0);
    for (int i = 0; i < 20 && !asleep; i++) tick();
    wake = 1'b1;
    tick();
    wake = 1'b0;
    wait_idle();
    lock_run();

    // R7 wake during the memory drain
    ack_mem_on = 1'b0;
    clear_flags();
    arm_pulse();
    for (int i = 0; i < 20 && !mem_drain_req; i++) tick();
    wake = 1'b1;
    tick();
    wake = 1'b0;
    tick();
    chk("R3 mem step waits for ack", int'(sref_req), 0);
    ack_mem_on = 1'b1;
    wait_idle();
    chk("R7 sref skipped", int'(seen_sref), 0);
    chk("R7 no sleep", int'(seen_sleep), 0);
    chk("R7 no timeout", int'(timeout_err), 0);

    // R7 wake during self-refresh
    ack_sref_on = 1'b0;
    top_keep = 1'b0;
    clear_flags();
    arm_pulse();
    for (int i = 0; i < 20 && !sref_req; i++) tick();
    wake = 1'b1;
    tick();
    wake = 1'b0;
    ack_sref_on = 1'b1;
    wait_idle();
    chk("R7 clock mask skipped", int'(seen_mask), 0);
    chk("R7 PLLs untouched", int'(pll_en), 7);
    chk("R7 back to idle", int'(bus_drain_req), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule